// File: doc/BRIEF.md
# Opcode-Fetch Wait-State Inserter

This block sits next to an 8-bit processor that has a Z80-style bus. It drives the processor's active-low WAIT input so that every opcode fetch is one clock longer, which gives slow ROM or RAM enough access time. A first stage captures the fetch marker (active-low M1) on the rising edge that starts T2, and its output is the WAIT line. The processor samples WAIT low on the falling edge inside T2 and enters one wait state (TW). On the edge that starts TW, a second stage copies the low level. Its low output presets the first stage at once, so WAIT is already high again when the processor samples it in TW. On the edge that starts T3, the second stage returns high and the sequencer is armed for the next fetch.

An active-low wait request from an expansion slot overrides the sequencer without waiting for a clock. It clears the first stage and presets the second, so WAIT falls at once and stays low for as long as the request is held, whatever the clock and M1 do. Once the request is withdrawn, the sequencer releases WAIT on the next rising edge and can serve a fetch one edge after that. An active-low reset puts both stages in their inactive state.

Top module: `fetch_wait_gen`

## Requirements
- R1: While reset is low and the slot request is high, WAIT is high, even if M1 is low.
- R2: When M1 is low at a rising clock edge, the request is high and the sequencer is idle, WAIT is low after that edge, so the processor sees it low at the falling edge inside T2.
- R3: With the request high, WAIT returns high before the falling edge inside TW, so each opcode fetch gets exactly one wait state.
- R4: Back-to-back opcode fetches each receive exactly one wait state, so the sequencer re-arms after every fetch.
- R5: When M1 is high at a rising edge and the request stays high, WAIT is high after that edge. Memory, I/O and refresh cycles therefore see no wait state.
- R6: A low slot request drives WAIT low immediately, without a clock edge, whatever the level of M1.
- R7: WAIT stays low at every sample point for as long as the slot request is low, whatever its length.
- R8: After the request returns high, WAIT is high after the next rising edge. A fetch whose T1 starts one edge later gets exactly one wait state.
- R9: A slot request that starts during a fetch's wait state holds WAIT low for its whole duration. The fetch then completes, and the next fetch gets exactly one wait state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; T-states begin on its rising edge |
| rstN | input | 1 | Active-low reset, asynchronous |
| m1N | input | 1 | Active-low opcode-fetch marker from the processor |
| extWaitN | input | 1 | Active-low wait request from the expansion slot, asynchronous |
| waitN | output | 1 | Active-low WAIT to the processor |

## Verification
Two functions can act in the same cycle: the self-release of the fetch sequencer, where the second stage presets the first during TW, and the asynchronous slot request, which clears that same first stage. The bench provokes the overlap by dropping the request a fraction of a clock after the edge that starts TW, which is exactly when the preset is active. It holds the request for random lengths and releases it mid-cycle while M1 is still low. It judges the result with a processor model that samples WAIT on every falling edge. WAIT must be low at every sample while the request is held, the stretched fetch must finish, and the fetch that follows must get exactly one wait state.

// File: rtl/owait_pkg.sv
package owait_pkg;

  // Asynchronous strobes from the control to the two storage stages (active high)
  typedef struct packed {
    logic setFirst;   // force first stage high (reset or self-release)
    logic clrFirst;   // force first stage low (slot request)
    logic setSecond;  // force second stage high (reset or slot request)
  } asyncStrobes_t;

  localparam logic WAIT_ASSERTED = 1'b0;
  localparam logic WAIT_RELEASED = 1'b1;

endpackage

// File: rtl/owait_ctrl.sv
module owait_ctrl
  import owait_pkg::*;
(
  input  logic          rstN,
  input  logic          extWaitN,
  input  logic          stage1Q,
  input  logic          stage2Q,
  output asyncStrobes_t strobes,
  output logic          waitN
);

  logic resetActive;
  logic slotRequest;
  logic selfRelease;

  always_comb begin
    resetActive = ~rstN;
    slotRequest = ~extWaitN;
    selfRelease = ~stage2Q;
  end

  // Reset outranks the slot request on the first stage; the slot request
  // outranks the self-release preset.
  always_comb begin
    strobes.clrFirst  = slotRequest & ~resetActive;
    strobes.setFirst  = resetActive | selfRelease;
    strobes.setSecond = resetActive | slotRequest;
  end

  always_comb begin
    waitN = (stage1Q == WAIT_ASSERTED) ? WAIT_ASSERTED : WAIT_RELEASED;
  end

endmodule

// File: rtl/owait_dp.sv
module owait_dp
  import owait_pkg::*;
(
  input  logic          clk,
  input  logic          m1N,
  input  asyncStrobes_t strobes,
  output logic          stage1Q,
  output logic          stage2Q
);

  logic setFirst;
  logic clrFirst;
  logic setSecond;

  always_comb begin
    setFirst  = strobes.setFirst;
    clrFirst  = strobes.clrFirst;
    setSecond = strobes.setSecond;
  end

  // First stage: captures the fetch marker; clear outranks set
  always_ff @(posedge clk or posedge clrFirst or posedge setFirst) begin
    if (clrFirst)      stage1Q <= 1'b0;
    else if (setFirst) stage1Q <= 1'b1;
    else               stage1Q <= m1N;
  end

  // Second stage: delayed copy of the first stage, used to end the wait
  always_ff @(posedge clk or posedge setSecond) begin
    if (setSecond) stage2Q <= 1'b1;
    else           stage2Q <= stage1Q;
  end

endmodule

// File: rtl/fetch_wait_gen.sv
module fetch_wait_gen
  import owait_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic m1N,
  input  logic extWaitN,
  output logic waitN
);

  asyncStrobes_t strobes;
  logic          stage1Q;
  logic          stage2Q;

  owait_ctrl u_ctrl (
    .rstN     (rstN),
    .extWaitN (extWaitN),
    .stage1Q  (stage1Q),
    .stage2Q  (stage2Q),
    .strobes  (strobes),
    .waitN    (waitN)
  );

  owait_dp u_dp (
    .clk     (clk),
    .m1N     (m1N),
    .strobes (strobes),
    .stage1Q (stage1Q),
    .stage2Q (stage2Q)
  );

endmodule

// File: rtl/fetch_wait_chk.sv
module fetch_wait_chk (
  input logic clk,
  input logic rstN,
  input logic m1N,
  input logic extWaitN,
  input logic waitN,
  input logic stage2Q
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    (!rstN && extWaitN) |-> waitN);

  assert_fetch_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    (extWaitN && !m1N && waitN && stage2Q) |=> !waitN);

  assert_single_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (extWaitN && !waitN) |=> (waitN || !extWaitN));

  assert_no_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    (extWaitN && m1N) |=> (waitN || !extWaitN));

  assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !extWaitN |-> !waitN);

endmodule

bind fetch_wait_gen fetch_wait_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .m1N      (m1N),
  .extWaitN (extWaitN),
  .waitN    (waitN),
  .stage2Q  (stage2Q)
);

// File: tb/sim_fetch_wait_gen.sv
module sim_fetch_wait_gen;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic m1N = 1'b1;
  logic extWaitN = 1'b1;
  logic waitN;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  fetch_wait_gen u0 (
    .clk      (clk),
    .rstN     (rstN),
    .m1N      (m1N),
    .extWaitN (extWaitN),
    .waitN    (waitN)
  );

  always #4 clk = ~clk;

  // Expected wait states for a bus cycle with the slot request idle
  function automatic int expectedWaits(bit isFetch);
    return isFetch ? 1 : 0;
  endfunction

  task automatic checkBit(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Processor model: opcode fetch T1 T2 [TW..] T3 T4, WAIT sampled on falling edges
  task automatic fetchCycle(string req);
    int waits = 0;
    @(posedge clk); #1 m1N = 1'b0;          // T1
    @(posedge clk); #1;                      // T2
    checkBit("R2 wait low in T2", waitN, 1'b0);
    @(negedge clk);
    while (!waitN && waits < 64) begin
      waits++;
      @(posedge clk);                        // TW
      @(negedge clk);
    end
    @(posedge clk); #1 m1N = 1'b1;          // T3
    @(posedge clk);                          // T4
    checkInt(req, waits, expectedWaits(1'b1));
  endtask

  // Memory, I/O or refresh cycle: M1 stays high
  task automatic plainCycle(int tStates);
    int waits = 0;
    @(posedge clk);                          // T1
    @(posedge clk);                          // T2
    @(negedge clk);
    while (!waitN && waits < 64) begin
      waits++;
      @(posedge clk);
      @(negedge clk);
    end
    repeat (tStates - 2) @(posedge clk);
    checkInt("R5 no wait without M1", waits, expectedWaits(1'b0));
  endtask

  // Slot request of len clocks, optionally wiggling M1 while held
  task automatic slotRequest(int len, bit wiggle);
    @(posedge clk); #2 extWaitN = 1'b0;
    #1 checkBit("R6 immediate wait", waitN, 1'b0);
    for (int i = 0; i < len; i++) begin
      if (wiggle) m1N = 1'($urandom_range(0, 1));
      @(negedge clk);
      checkBit("R7 held wait", waitN, 1'b0);
      @(posedge clk); #2;
    end
    m1N = 1'b1;
    extWaitN = 1'b1;
    @(posedge clk); #1;
    checkBit("R8 release after edge", waitN, 1'b1);
  endtask

  // Slot request that starts in TW of a fetch
  task automatic overlapFetch(int len);
    int waits = 0;
    @(posedge clk); #1 m1N = 1'b0;          // T1
    @(posedge clk);                          // T2
    @(negedge clk);
    checkBit("R9 fetch wait before request", waitN, 1'b0);
    @(posedge clk); #2 extWaitN = 1'b0;     // TW, preset active
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      checkBit("R9 wait held during overlap", waitN, 1'b0);
      @(posedge clk); #2;
    end
    extWaitN = 1'b1;
    @(negedge clk);
    while (!waitN && waits < 64) begin
      waits++;
      @(posedge clk);
      @(negedge clk);
    end
    checkBit("R9 overlapped fetch completes", waitN, 1'b1);
    @(posedge clk); #1 m1N = 1'b1;          // T3
    @(posedge clk);                          // T4
    fetchCycle("R9 fetch after overlap");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A7E));
    #3 rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkBit("R1 reset state", waitN, 1'b1);
    @(posedge clk); #1 m1N = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkBit("R1 reset overrides M1", waitN, 1'b1);
    m1N = 1'b1;
    @(posedge clk); #2 rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkBit("R1 idle after reset", waitN, 1'b1);

    // Directed corner cases
    fetchCycle("R3 single wait");
    fetchCycle("R4 back-to-back fetch");
    fetchCycle("R4 back-to-back fetch");
    plainCycle(3);
    plainCycle(4);
    slotRequest(1, 1'b0);
    @(posedge clk);
    fetchCycle("R8 fetch after release");
    slotRequest(17, 1'b1);
    @(posedge clk);
    fetchCycle("R8 fetch after long request");
    overlapFetch(1);
    overlapFetch(9);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom_range(0, 4))
        0, 1: fetchCycle("R4 random fetch");
        2:    plainCycle(int'($urandom_range(3, 4)));
        3: begin
          slotRequest(int'($urandom_range(1, 24)), 1'($urandom_range(0, 1)));
          @(posedge clk);
        end
        default: begin
          if ($urandom_range(0, 3) == 0) overlapFetch(int'($urandom_range(1, 12)));
          else repeat ($urandom_range(1, 3)) @(posedge clk);
        end
      endcase
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule